// File: doc/BRIEF.md
# Four-Mode Scannable Test Latch Row

This block is a row of W test-capable storage cells placed at the boundary between two combinational stages of a latch-based pipeline. In mission operation each cell behaves as a positive-level latch on a phase clock. During delay test, a cell can also do one of three other things. It can drive a pattern that was shifted in beforehand, releasing it onto its output on a phase-clock rising edge. It can sample the stage's response on a rising phase edge. It can sample the response on a falling phase edge. The cells are joined into one serial chain, so patterns are loaded and responses are unloaded one bit per clock.

The whole row runs on one fast system clock. The phase clock is treated as a data input that is sampled on each system clock, and its edges are found by comparing it with its value on the previous cycle. One storage bit per cell holds both the shifted-in launch value and the captured response. The test controller picks a mode for the whole row at the start of each session. The mode takes effect one clock after it is presented.

Top module: `scan_test_latch`

## Requirements
- R1: While reset is high, the row enters pass mode on the next clock, and all cell outputs, all chain bits and scan_out read 0.
- R2: In pass mode (mode 2'b00), with shift_en low and phi high at a clock edge, q takes the d value present at that edge.
- R3: In pass mode, with phi low at a clock edge, q keeps its value.
- R4: In launch mode (mode 2'b01), q loads the cell's chain bit only at an edge where phi is high and was low at the previous edge. At other edges q holds.
- R5: In rise-capture mode (mode 2'b10), each cell's chain bit loads d at a rising phi edge and ignores the falling edge.
- R6: In fall-capture mode (mode 2'b11), each cell's chain bit loads d at a falling phi edge (phi low, previously high) and ignores the rising edge.
- R7: While shift_en is high, each edge moves the chain one place: bit 0 takes scan_in, bit i takes bit i-1, and scan_out shows bit W-1. Shifting takes priority over capture.
- R8: While shift_en is high, q holds its value in every mode.
- R9: A captured value stays unchanged until the next capture edge of the active mode or the next shift, even when d changes.
- R10: In both capture modes, q holds its value.
- R11: A value on the mode input governs the edges after the clock that registers it. The row's behaviour is set by the mode registered one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phi | input | 1 | Phase clock, sampled as data |
| mode | input | 2 | 00 pass, 01 launch, 10 rise-capture, 11 fall-capture |
| shift_en | input | 1 | Serial shift of the chain |
| scan_in | input | 1 | Serial input into chain bit 0 |
| d | input | W | Functional data from the upstream stage |
| q | output | W | Functional data to the downstream stage |
| scan_out | output | 1 | Chain bit W-1 |

## Verification
The bench targets the edge qualification of each mode. A launch that fires on every high phase, rather than only on the rise, would overwrite q when the chain shifts while phi stays high. A capture that takes the wrong edge would unload the d value applied after the intended edge, not the response at that edge. The bench shifts with phi rising and capture mode active, which catches a design that gives capture priority over the shift, because the unloaded pattern would be corrupted. It also checks that q holds during shifts and in capture modes, because a cell that stays transparent there would leak d into the downstream stage.

// File: rtl/scan_latch_pkg.sv
package scan_latch_pkg;
  typedef enum logic [1:0] {
    MODE_PASS     = 2'b00,
    MODE_LAUNCH   = 2'b01,
    MODE_CAP_RISE = 2'b10,
    MODE_CAP_FALL = 2'b11
  } cell_mode_e;
endpackage

// File: rtl/phase_edge_det.sv
module phase_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic phi,
  output logic rise,
  output logic fall
);
  logic phi_q;

  always_ff @(posedge clk) begin
    if (rst) phi_q <= 1'b0;
    else     phi_q <= phi;
  end

  assign rise = phi & ~phi_q;
  assign fall = ~phi & phi_q;
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import scan_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_in,
  input  logic       phi,
  input  logic       rise,
  input  logic       fall,
  output cell_mode_e mode_q,
  output logic       pass_en,
  output logic       launch_en,
  output logic       cap_en
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_PASS;
    else     mode_q <= cell_mode_e'(mode_in);
  end

  always_comb begin
    pass_en   = 1'b0;
    launch_en = 1'b0;
    cap_en    = 1'b0;
    unique case (mode_q)
      MODE_PASS:     pass_en   = phi;
      MODE_LAUNCH:   launch_en = rise;
      MODE_CAP_RISE: cap_en    = rise;
      MODE_CAP_FALL: cap_en    = fall;
      default: ;
    endcase
  end
endmodule

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic shift_en,
  input  logic shift_in,
  input  logic pass_en,
  input  logic launch_en,
  input  logic cap_en,
  output logic q,
  output logic chain_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q         <= 1'b0;
      chain_bit <= 1'b0;
    end else begin
      if (shift_en)    chain_bit <= shift_in;
      else if (cap_en) chain_bit <= d;

      if (!shift_en) begin
        if (pass_en)        q <= d;
        else if (launch_en) q <= chain_bit;
      end
    end
  end
endmodule

// File: rtl/scan_test_latch.sv
module scan_test_latch
  import scan_latch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         phi,
  input  logic [1:0]   mode,
  input  logic         shift_en,
  input  logic         scan_in,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         scan_out
);
  localparam int LAST = W - 1;

  logic       rise, fall;
  logic       pass_en, launch_en, cap_en;
  cell_mode_e mode_q;
  logic [W-1:0] chain;
  logic [W-1:0] link_in;

  phase_edge_det u_edge (
    .clk (clk), .rst (rst), .phi (phi), .rise (rise), .fall (fall)
  );

  mode_ctrl u_mode (
    .clk (clk), .rst (rst), .mode_in (mode), .phi (phi),
    .rise (rise), .fall (fall), .mode_q (mode_q),
    .pass_en (pass_en), .launch_en (launch_en), .cap_en (cap_en)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign link_in[i] = scan_in;
    end else begin : g_body
      assign link_in[i] = chain[i-1];
    end

    scan_cell u_cell (
      .clk (clk), .rst (rst), .d (d[i]), .shift_en (shift_en),
      .shift_in (link_in[i]), .pass_en (pass_en),
      .launch_en (launch_en), .cap_en (cap_en),
      .q (q[i]), .chain_bit (chain[i])
    );
  end

  assign scan_out = chain[LAST];
endmodule

// File: rtl/scan_test_latch_chk.sv
module scan_test_latch_chk
  import scan_latch_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         phi,
  input logic         shift_en,
  input logic         scan_in,
  input logic [W-1:0] d,
  input logic [W-1:0] q,
  input logic         scan_out,
  input cell_mode_e   mode_q,
  input logic [W-1:0] chain
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (q == '0 && scan_out == 1'b0 && chain == '0));

  assert_pass_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PASS && phi && !shift_en) |=> q == $past(d));

  assert_pass_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PASS && !phi) |=> $stable(q));

  assert_launch_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LAUNCH && phi && !$past(phi) && !shift_en)
      |=> q == $past(chain));

  assert_shift_entry_R7: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> chain[0] == $past(scan_in));

  assert_shift_holds_q_R8: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> $stable(q));

  assert_capture_holds_q_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1] && !shift_en) |=> $stable(q));
endmodule

bind scan_test_latch scan_test_latch_chk #(.W(W)) u_chk (
  .clk (clk), .rst (rst), .phi (phi), .shift_en (shift_en),
  .scan_in (scan_in), .d (d), .q (q), .scan_out (scan_out),
  .mode_q (mode_q), .chain (chain)
);

// File: tb/scan_test_latch_tb_top.sv
module scan_test_latch_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         phi = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         shift_en = 1'b0;
  logic         scan_in = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q;
  logic         scan_out;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 0;
  string phase = "R1";

  // reference model state
  bit    m_q[W];
  bit    m_chain[$];
  int    m_mode = 0;
  bit    m_phi_prev = 0;

  always #4 clk = ~clk;

  scan_test_latch #(.W(W)) dut_i (
    .clk (clk), .rst (rst), .phi (phi), .mode (mode),
    .shift_en (shift_en), .scan_in (scan_in), .d (d),
    .q (q), .scan_out (scan_out)
  );

  initial begin
    for (int i = 0; i < W; i++) m_chain.push_back(1'b0);
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < W; i++) begin m_q[i] = 0; m_chain[i] = 0; end
      m_mode = 0;
      m_phi_prev = 0;
    end else begin
      bit up, down;
      up   = phi && !m_phi_prev;
      down = !phi && m_phi_prev;
      if (shift_en) begin
        m_chain.push_front(scan_in);
        void'(m_chain.pop_back());
      end else begin
        if (m_mode == 0 && phi) for (int i = 0; i < W; i++) m_q[i] = d[i];
        if (m_mode == 1 && up)  for (int i = 0; i < W; i++) m_q[i] = m_chain[i];
        if ((m_mode == 2 && up) || (m_mode == 3 && down))
          for (int i = 0; i < W; i++) m_chain[i] = d[i];
      end
      m_mode = int'(mode);
      m_phi_prev = phi;
    end
  end

  function automatic logic [W-1:0] model_q();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = m_q[i];
    return v;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (q !== model_q() || scan_out !== m_chain[W-1]) begin
        n_fail++;
        $display("FAIL %s per-clock: q=%h so=%b expected q=%h so=%b",
                 phase, q, scan_out, model_q(), m_chain[W-1]);
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(logic [W-1:0] pat);
    shift_en = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin scan_in = pat[i]; cyc(); end
    shift_en = 1'b0;
    scan_in = 1'b0;
  endtask

  task automatic unload(output logic [W-1:0] got);
    shift_en = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin got[i] = scan_out; cyc(); end
    shift_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got;
    @(negedge clk);
    cyc(2);
    check("R1 reset q", q, '0);
    check("R1 reset scan_out", {{(W-1){1'b0}}, scan_out}, '0);
    rst = 1'b0;
    cyc();

    // pass mode
    phase = "R2";
    d = 8'hA5; phi = 1'b1; cyc();
    check("R2 follow", q, 8'hA5);
    d = 8'h5B; cyc();
    check("R2 follow second", q, 8'h5B);
    phase = "R3";
    phi = 1'b0; cyc(); d = 8'h3C; cyc(2);
    check("R3 hold low", q, 8'h5B);

    // preload, q held during shift
    phase = "R8";
    phi = 1'b1; load(8'h96);
    check("R8 q held during shift in pass mode", q, 8'h5B);

    // launch mode
    phase = "R11";
    phi = 1'b0; mode = 2'b01; d = 8'hFF;
    @(posedge clk); #1; mode = 2'b01; @(negedge clk);
    phase = "R4";
    cyc();
    check("R4 no launch while low", q, 8'h5B);
    phi = 1'b1; cyc();
    check("R4 launch on rise", q, 8'h96);
    load(8'h21);
    cyc(2);
    check("R4 no relaunch while high", q, 8'h96);
    phi = 1'b0; cyc(); phi = 1'b1; cyc();
    check("R4 relaunch next rise", q, 8'h21);

    // rise capture
    phase = "R5";
    mode = 2'b10; phi = 1'b0; cyc(2);
    d = 8'h5A; phi = 1'b1; cyc();
    d = 8'hFF; cyc(); phi = 1'b0; cyc(); d = 8'h00; cyc();
    check("R10 q held in rise-capture", q, 8'h21);
    phase = "R9";
    unload(got);
    check("R5 R9 rise capture unloaded", got, 8'h5A);

    // fall capture
    phase = "R6";
    mode = 2'b11; phi = 1'b1; cyc(2);
    d = 8'hC3; phi = 1'b0; cyc();
    d = 8'h11; phi = 1'b1; cyc(2);
    check("R10 q held in fall-capture", q, 8'h21);
    unload(got);
    check("R6 fall capture unloaded", got, 8'hC3);

    // shift priority over capture
    phase = "R7";
    mode = 2'b10; phi = 1'b0; cyc(2);
    shift_en = 1'b1;
    d = 8'hFF;
    for (int i = W - 1; i >= 0; i--) begin
      scan_in = 8'h4E >> i;
      phi = ~phi;
      cyc();
    end
    shift_en = 1'b0; phi = 1'b0; d = 8'hFF; cyc();
    phi = 1'b0; mode = 2'b00; cyc();
    unload(got);
    check("R7 shift beats capture", got, 8'h4E);

    // mode change latency: pass mode registered, then phi high
    phase = "R11";
    mode = 2'b01; phi = 1'b1; d = 8'h77; cyc();
    check("R11 old pass mode still active", q, 8'h77);
    d = 8'h88; cyc();
    check("R11 launch mode now active", q, 8'h77);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule